// File: doc/BRIEF.md
# CSI-2 Capture Context Packet Filter

This block sits behind a CSI-2 packet decoder and picks out the long packets that belong to one capture context. Each frame-start, frame-end and line header arrives as a one-cycle strobe carrying its virtual channel and data type. Payload bytes follow a line header. A line is accepted when its virtual channel matches the context's channel setting and its data type matches the context's type setting. A type setting of 0x01 lets every data type through. Useful type codes are 0x1E (YUV422, 4 bytes per 2 pixels), 0x24 (RGB888, 3 bytes per pixel), 0x2A (RAW8, 1 byte per pixel) and 0x2B (RAW10, 5 bytes per 4 pixels).

Accepted payload bytes leave one cycle later, tagged with the context's output port number. The first byte of each line is marked, so the output is grouped on line boundaries. A line budget bounds every frame. Lines beyond the budget are dropped and set a sticky overrun flag. A frame that ends short of the budget sets a sticky underrun flag.

Configuration is written through a valid/ready port into staging registers. These registers are copied into the active set only when a frame start arrives on the staged virtual channel.

Top module: `csi_ctx_filter`

## Requirements
- R1: A line header or frame end whose virtual channel differs from the active channel forwards no bytes and leaves the line count unchanged. A frame start whose channel differs from the staged channel is ignored.
- R2: When the active type setting is not 0x01, a line is forwarded only if its data type equals that setting exactly.
- R3: When the active type setting is 0x01, lines of every data type on the matching channel are forwarded.
- R4: Each payload byte of an accepted line appears on outByte one cycle after its input cycle, with outValid high and outPort equal to the active port. outSol is high on the first byte of each line and only on that byte.
- R5: A matching frame start clears the line count. A matching line that arrives once the count already equals the active line budget is dropped, and it sets ovrFlag, which stays high until reset.
- R6: A matching frame end that arrives while the count is below the active budget sets undFlag, which stays high until reset. A frame end at exactly the budget leaves undFlag unchanged.
- R7: Writes to the configuration (address 0 = channel, 1 = data type, 2 = line budget, 3 = output port) take effect only at the next frame start. cfgReady is always high.
- R8: After reset, outValid, outSol, ovrFlag and undFlag are 0. The reset configuration is channel 0, data type 0x01, budget RESET_LINES and port 0.
- R9: Line headers and bytes that arrive outside a frame, meaning before the first matching frame start or after a matching frame end, forward nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration write request |
| cfgReady | output | 1 | Configuration write accepted (always 1) |
| cfgAddr | input | 2 | Configuration register select |
| cfgData | input | CFG_W | Configuration write data |
| pktFs | input | 1 | Frame-start strobe |
| pktFe | input | 1 | Frame-end strobe |
| pktLs | input | 1 | Line (long packet) header strobe |
| pktVc | input | VC_W | Virtual channel of the current strobe |
| pktDt | input | 6 | Data type of the current line header |
| pktByteValid | input | 1 | Payload byte valid |
| pktByte | input | 8 | Payload byte |
| outValid | output | 1 | Forwarded byte valid |
| outByte | output | 8 | Forwarded byte |
| outPort | output | PORT_W | Output port tag |
| outSol | output | 1 | First byte of a line |
| ovrFlag | output | 1 | Sticky line overrun |
| undFlag | output | 1 | Sticky line underrun |

## Verification
The assertions check on every cycle that both flags stay high once set, that ovrFlag rises only after a line header and undFlag only after a frame end, and that every forwarded byte follows an input byte. They also check that a line-start mark always comes with a valid byte. The bench scenarios are needed to show the filtering itself: channel and type matching, the wildcard code, the port tag, the counter clearing on frame start, the exact budget boundary, and the delay of a configuration write until the next frame.

// File: rtl/csi_filt_pkg.sv
package csi_filt_pkg;

  localparam int DT_W = 6;
  localparam logic [DT_W-1:0] DT_ANY = 6'h01;

  typedef enum logic [1:0] {
    ADDR_VC    = 2'd0,
    ADDR_DT    = 2'd1,
    ADDR_LINES = 2'd2,
    ADDR_PORT  = 2'd3
  } cfgAddr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic openLine;
    logic closeLine;
  } lineStrobe_t;

endpackage

// File: rtl/ctx_filter_ctrl.sv
module ctx_filter_ctrl
  import csi_filt_pkg::*;
#(
  parameter int VC_W        = 2,
  parameter int LINE_W      = 12,
  parameter int PORT_W      = 3,
  parameter int CFG_W       = 16,
  parameter int RESET_LINES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [1:0]        cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              pktFs,
  input  logic              pktFe,
  input  logic              pktLs,
  input  logic [VC_W-1:0]   pktVc,
  input  logic [DT_W-1:0]   pktDt,
  output lineStrobe_t       strobe,
  output logic [PORT_W-1:0] activePort,
  output logic              ovrFlag,
  output logic              undFlag
);

  localparam logic [LINE_W-1:0] LINES_INIT = LINE_W'(RESET_LINES);

  // staging set, written by the config port
  logic [VC_W-1:0]   stVc;
  logic [DT_W-1:0]   stDt;
  logic [LINE_W-1:0] stLines;
  logic [PORT_W-1:0] stPort;

  // active set, loaded at frame start
  logic [VC_W-1:0]   acVc;
  logic [DT_W-1:0]   acDt;
  logic [LINE_W-1:0] acLines;
  logic [PORT_W-1:0] acPort;

  logic [LINE_W-1:0] lineCnt;
  logic              inFrame;

  logic fsHit, feHit, lsHit, dtOk, budgetLeft;

  always_comb begin
    fsHit      = pktFs && (pktVc == stVc);
    feHit      = pktFe && inFrame && (pktVc == acVc);
    dtOk       = (acDt == DT_ANY) || (pktDt == acDt);
    lsHit      = pktLs && inFrame && (pktVc == acVc) && dtOk;
    budgetLeft = lineCnt < acLines;
    strobe.openLine  = lsHit && budgetLeft;
    strobe.closeLine = pktFs || pktFe || (pktLs && !(lsHit && budgetLeft));
  end

  assign activePort = acPort;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stVc    <= '0;
      stDt    <= DT_ANY;
      stLines <= LINES_INIT;
      stPort  <= '0;
    end else if (cfgValid) begin
      case (cfgAddr_t'(cfgAddr))
        ADDR_VC:    stVc    <= cfgData[VC_W-1:0];
        ADDR_DT:    stDt    <= cfgData[DT_W-1:0];
        ADDR_LINES: stLines <= cfgData[LINE_W-1:0];
        ADDR_PORT:  stPort  <= cfgData[PORT_W-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acVc    <= '0;
      acDt    <= DT_ANY;
      acLines <= LINES_INIT;
      acPort  <= '0;
      lineCnt <= '0;
      inFrame <= 1'b0;
      ovrFlag <= 1'b0;
      undFlag <= 1'b0;
    end else if (fsHit) begin
      acVc    <= stVc;
      acDt    <= stDt;
      acLines <= stLines;
      acPort  <= stPort;
      lineCnt <= '0;
      inFrame <= 1'b1;
    end else begin
      if (lsHit) begin
        if (budgetLeft) lineCnt <= lineCnt + 1'b1;
        else            ovrFlag <= 1'b1;
      end
      if (feHit) begin
        inFrame <= 1'b0;
        if (budgetLeft) undFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ctx_filter_dp.sv
module ctx_filter_dp
  import csi_filt_pkg::*;
#(
  parameter int PORT_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       strobe,
  input  logic [PORT_W-1:0] activePort,
  input  logic              pktByteValid,
  input  logic [BYTE_W-1:0] pktByte,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic [PORT_W-1:0] outPort,
  output logic              outSol
);

  logic lineOpen;
  logic solPending;
  logic fire;

  assign fire = lineOpen && pktByteValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineOpen   <= 1'b0;
      solPending <= 1'b0;
    end else if (strobe.openLine) begin
      lineOpen   <= 1'b1;
      solPending <= 1'b1;
    end else begin
      if (strobe.closeLine) lineOpen <= 1'b0;
      if (fire) solPending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSol   <= 1'b0;
      outByte  <= '0;
      outPort  <= '0;
    end else begin
      outValid <= fire;
      outSol   <= fire && solPending;
      if (fire) begin
        outByte <= pktByte;
        outPort <= activePort;
      end
    end
  end

endmodule

// File: rtl/csi_ctx_filter.sv
module csi_ctx_filter
  import csi_filt_pkg::*;
#(
  parameter int VC_W        = 2,
  parameter int LINE_W      = 12,
  parameter int PORT_W      = 3,
  parameter int CFG_W       = 16,
  parameter int RESET_LINES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  output logic              cfgReady,
  input  logic [1:0]        cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              pktFs,
  input  logic              pktFe,
  input  logic              pktLs,
  input  logic [VC_W-1:0]   pktVc,
  input  logic [5:0]        pktDt,
  input  logic              pktByteValid,
  input  logic [7:0]        pktByte,
  output logic              outValid,
  output logic [7:0]        outByte,
  output logic [PORT_W-1:0] outPort,
  output logic              outSol,
  output logic              ovrFlag,
  output logic              undFlag
);

  lineStrobe_t       strobe;
  logic [PORT_W-1:0] activePort;

  assign cfgReady = 1'b1;

  ctx_filter_ctrl #(
    .VC_W(VC_W), .LINE_W(LINE_W), .PORT_W(PORT_W),
    .CFG_W(CFG_W), .RESET_LINES(RESET_LINES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .pktFs(pktFs), .pktFe(pktFe), .pktLs(pktLs),
    .pktVc(pktVc), .pktDt(pktDt),
    .strobe(strobe), .activePort(activePort),
    .ovrFlag(ovrFlag), .undFlag(undFlag)
  );

  ctx_filter_dp #(.PORT_W(PORT_W), .BYTE_W(8)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .activePort(activePort),
    .pktByteValid(pktByteValid), .pktByte(pktByte),
    .outValid(outValid), .outByte(outByte),
    .outPort(outPort), .outSol(outSol)
  );

endmodule

// File: rtl/csi_ctx_filter_chk.sv
module csi_ctx_filter_chk (
  input logic clk,
  input logic rstN,
  input logic pktFe,
  input logic pktLs,
  input logic pktByteValid,
  input logic outValid,
  input logic outSol,
  input logic ovrFlag,
  input logic undFlag
);

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag |=> ovrFlag);

  assert_ovr_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(pktLs));

  assert_und_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    undFlag |=> undFlag);

  assert_und_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(undFlag) |-> $past(pktFe));

  assert_sol_with_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    outSol |-> outValid);

  assert_fwd_from_input_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(pktByteValid));

endmodule

bind csi_ctx_filter csi_ctx_filter_chk u_chk (
  .clk(clk), .rstN(rstN), .pktFe(pktFe), .pktLs(pktLs),
  .pktByteValid(pktByteValid), .outValid(outValid), .outSol(outSol),
  .ovrFlag(ovrFlag), .undFlag(undFlag)
);

// File: tb/sim_csi_ctx_filter.sv
`timescale 1ns/1ps
module sim_csi_ctx_filter;

  logic clk = 1'b0;
  logic rstN;
  logic cfgValid;
  logic cfgReady;
  logic [1:0] cfgAddr;
  logic [15:0] cfgData;
  logic pktFs, pktFe, pktLs;
  logic [1:0] pktVc;
  logic [5:0] pktDt;
  logic pktByteValid;
  logic [7:0] pktByte;
  logic outValid;
  logic [7:0] outByte;
  logic [2:0] outPort;
  logic outSol;
  logic ovrFlag, undFlag;

  always #4 clk = ~clk;

  csi_ctx_filter u0 (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgReady(cfgReady),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .pktFs(pktFs), .pktFe(pktFe),
    .pktLs(pktLs), .pktVc(pktVc), .pktDt(pktDt), .pktByteValid(pktByteValid),
    .pktByte(pktByte), .outValid(outValid), .outByte(outByte),
    .outPort(outPort), .outSol(outSol), .ovrFlag(ovrFlag), .undFlag(undFlag)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // monitor, sampled on the falling edge
  int fwdCnt = 0;
  int solCnt = 0;
  int lastPort = 0;
  int firstByte = -1;

  always @(negedge clk) begin
    if (outValid) begin
      fwdCnt++;
      lastPort = outPort;
    end
    if (outSol) begin
      solCnt++;
      if (firstByte < 0) firstByte = outByte;
    end
  end

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  task automatic clearMon();
    @(negedge clk);
    fwdCnt = 0; solCnt = 0; lastPort = 0; firstByte = -1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; cfgValid = 0; cfgAddr = 0; cfgData = 0;
    pktFs = 0; pktFe = 0; pktLs = 0; pktVc = 0; pktDt = 0;
    pktByteValid = 0; pktByte = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic cfgWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    cfgValid = 1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgValid = 0;
  endtask

  task automatic sendFs(logic [1:0] vc);
    @(negedge clk); pktFs = 1; pktVc = vc;
    @(negedge clk); pktFs = 0;
  endtask

  task automatic sendFe(logic [1:0] vc);
    @(negedge clk); pktFe = 1; pktVc = vc;
    @(negedge clk); pktFe = 0;
  endtask

  task automatic sendLine(logic [1:0] vc, logic [5:0] dt, int n, logic [7:0] base);
    @(negedge clk); pktLs = 1; pktVc = vc; pktDt = dt;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pktLs = 0; pktByteValid = 1; pktByte = base + 8'(i);
    end
    @(negedge clk); pktLs = 0; pktByteValid = 0;
    repeat (2) @(negedge clk);
  endtask

  // {cfgDt, vc, dt, expected bytes}; configured channel is 0, 3 bytes per line
  localparam int NV = 7;
  localparam logic [17:0] VECS [NV] = '{
    {6'h2A, 2'd0, 6'h2A, 4'd3},  // R2 exact match
    {6'h2A, 2'd0, 6'h2B, 4'd0},  // R2 mismatch dropped
    {6'h01, 2'd0, 6'h24, 4'd3},  // R3 wildcard
    {6'h01, 2'd0, 6'h1E, 4'd3},  // R3 wildcard
    {6'h1E, 2'd1, 6'h1E, 4'd0},  // R1 wrong channel
    {6'h24, 2'd0, 6'h24, 4'd3},  // R2 exact match
    {6'h01, 2'd3, 6'h2B, 4'd0}   // R1 wrong channel under wildcard
  };

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    rstN = 0;
    doReset();
    @(negedge clk);
    // R8 reset state
    check("R8 outValid", outValid, 0);
    check("R8 outSol", outSol, 0);
    check("R8 ovrFlag", ovrFlag, 0);
    check("R8 undFlag", undFlag, 0);
    check("R7 cfgReady", cfgReady, 1);

    // R8 defaults: channel 0, wildcard type, port 0
    clearMon();
    sendFs(0);
    sendLine(0, 6'h2B, 2, 8'h10);
    check("R8 default forward", fwdCnt, 2);
    check("R8 default port", lastPort, 0);
    sendFe(0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      cfgWrite(2'd1, {10'd0, VECS[k][17:12]});
      cfgWrite(2'd2, 16'd4);
      sendFs(0);
      clearMon();
      sendLine(VECS[k][11:10], VECS[k][9:4], 3, 8'h40);
      check("R1/R2/R3 filter", fwdCnt, int'(VECS[k][3:0]));
      sendFe(0);
    end

    // R4 port tag, latency and line-start mark
    doReset();
    cfgWrite(2'd3, 16'd5);
    sendFs(0);
    clearMon();
    sendLine(0, 6'h2A, 3, 8'hA0);
    check("R4 byte count", fwdCnt, 3);
    check("R4 port tag", lastPort, 5);
    check("R4 one sol per line", solCnt, 1);
    check("R4 first byte", firstByte, 8'hA0);
    clearMon();
    @(negedge clk); pktLs = 1; pktVc = 0; pktDt = 6'h2A;
    @(negedge clk); pktLs = 0; pktByteValid = 1; pktByte = 8'h77;
    @(posedge clk); #1;
    check("R4 one-cycle latency", outValid, 1);
    check("R4 latency byte", outByte, 8'h77);
    @(negedge clk); pktByteValid = 0;
    repeat (2) @(negedge clk);

    // R5 budget and overrun, R1 other channel does not count
    doReset();
    cfgWrite(2'd2, 16'd2);
    sendFs(0);
    clearMon();
    sendLine(2, 6'h2A, 2, 8'h00);
    sendLine(0, 6'h2A, 2, 8'h00);
    sendLine(0, 6'h2A, 2, 8'h00);
    check("R1 other channel no count", ovrFlag, 0);
    check("R5 within budget", fwdCnt, 4);
    sendFe(1);
    check("R1 other channel FE ignored", undFlag, 0);
    sendLine(0, 6'h2A, 2, 8'h00);
    check("R5 excess dropped", fwdCnt, 4);
    check("R5 overrun set", ovrFlag, 1);
    sendFe(0);
    check("R6 exact budget no underrun", undFlag, 0);
    sendLine(0, 6'h2A, 2, 8'h00);
    check("R5 overrun sticky", ovrFlag, 1);
    check("R9 after frame end", fwdCnt, 4);
    // counter clears on frame start
    sendFs(0);
    clearMon();
    sendLine(0, 6'h2A, 2, 8'h00);
    check("R5 count cleared on frame start", fwdCnt, 2);
    sendFe(0);
    check("R6 underrun set", undFlag, 1);
    sendFs(0);
    sendLine(0, 6'h2A, 2, 8'h00);
    sendLine(0, 6'h2A, 2, 8'h00);
    sendFe(0);
    check("R6 underrun sticky", undFlag, 1);

    // R9 nothing before first frame start
    doReset();
    clearMon();
    sendLine(0, 6'h2A, 3, 8'h00);
    check("R9 before frame start", fwdCnt, 0);
    check("R9 no flags", ovrFlag + undFlag, 0);

    // R7 mid-frame config deferred
    doReset();
    cfgWrite(2'd3, 16'd2);
    sendFs(0);
    cfgWrite(2'd3, 16'd6);
    cfgWrite(2'd1, 16'h2B);
    clearMon();
    sendLine(0, 6'h2A, 2, 8'h00);
    check("R7 old port kept", lastPort, 2);
    check("R7 old type kept", fwdCnt, 2);
    sendFe(0);
    sendFs(0);
    clearMon();
    sendLine(0, 6'h2B, 2, 8'h00);
    check("R7 new port applied", lastPort, 6);
    sendLine(0, 6'h2A, 2, 8'h00);
    check("R7 new type applied", fwdCnt, 2);
    // channel change: frame start on the old channel is ignored
    cfgWrite(2'd0, 16'd3);
    sendFe(0);
    sendFs(0);
    clearMon();
    sendLine(0, 6'h2B, 2, 8'h00);
    check("R1 old channel frame ignored", fwdCnt, 0);
    sendFs(3);
    sendLine(3, 6'h2B, 2, 8'h00);
    check("R7 new channel applied", fwdCnt, 2);

    report();
  end

endmodule